// File: doc/BRIEF.md
# Exception Lifecycle Tracker

This block holds the pending and active state of every exception vector of an interrupt controller and moves each vector through its life: it becomes pending when software or hardware raises it, active when the core takes it, and idle again when its handler finishes. It also records the level of each external interrupt line. A line that rises makes its vector pending. A line that is still high when its handler completes makes the vector pending again, so level-sensitive sources are not lost.

Configurable fault vectors are redirected to the hard fault when they cannot be taken. This happens when they are disabled, or when their priority does not beat the current execution priority supplied by the priority resolver. A redirection sets a sticky forced-fault flag. If the core already runs at negative priority, the redirection cannot happen: the block raises a lockup pulse instead and pends nothing. Each completion returns a one-cycle response that tells whether the completion was legal and whether the core goes back to base level. Priority arbitration and register access sit outside this block.

All event inputs are single-cycle strobes sampled on the rising clock edge. All state outputs reflect the events one edge later. No event can be refused, so there is no back-pressure. The completion response is a valid-only pulse that the consumer must take in the cycle it appears.

Top module: `exc_lifecycle`

## Requirements
- R1: After reset all pending and active bits are 0, and `forced_o`, `lockup_o` and `cmpl_valid_o` are 0.
- R2: A set strobe on a non-fault vector with an index from 1 to NUM_VEC-1 makes that vector pending on the next edge. Index 0 is ignored. A clear strobe makes the vector not pending. Clearing a vector that is not pending leaves all state unchanged.
- R3: A set strobe on a vector with index 3 to 13 is escalated when either condition holds:
  - the vector's priority is greater than or equal to `exec_prio_i` (vector 3 counts as priority -1, others use their 8-bit field `vec_prio_i[8v+7:8v]`), or
  - the vector is disabled (`vec_en_i[v]`=0; ignored for vector 3).

  On escalation vector 3 becomes pending instead, and `forced_o` goes to 1 and stays 1 until reset. Vector 14 and above are never escalated.
- R4: If escalation is needed while `exec_prio_i` (10-bit two's complement) is negative, the following hold:
  - `lockup_o` pulses high for exactly one cycle after the strobe.
  - Nothing becomes pending.
  - `forced_o` is unchanged.
- R5: An acknowledge strobe sets the vector's active bit and clears its pending bit.
- R6: A completion of a vector that is not active gives `cmpl_valid_o`=1 and `cmpl_err_o`=1 with `cmpl_base_o`=0 one cycle later. It leaves the vector state unchanged.
- R7: A completion of an active vector clears its active bit. It gives `cmpl_valid_o`=1 and `cmpl_err_o`=0. `cmpl_base_o`=1 exactly when at most one vector was active before the completion.
- R8: When an external vector (index 16+k, line k) completes while its recorded line level is high, it becomes pending again.
- R9: A low-to-high change of `line_i[k]` makes vector 16+k pending on the next edge. A falling edge and a steady high only record the level.
- R10: Events in one cycle are applied in this order:
  1. completion
  2. acknowledge
  3. line rises and set-pending
  4. clear-pending, which therefore wins

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | NUM_LINES | External interrupt line levels |
| vec_en_i | input | NUM_VEC | Per-vector enable |
| vec_prio_i | input | 8*NUM_VEC | Per-vector 8-bit priority, vector v at bits 8v+7:8v |
| exec_prio_i | input | 10 | Current execution priority, signed |
| set_i | input | 1 | Set-pending strobe |
| set_vec_i | input | IW | Set-pending vector index |
| clr_i | input | 1 | Clear-pending strobe |
| clr_vec_i | input | IW | Clear-pending vector index |
| ack_i | input | 1 | Acknowledge strobe |
| ack_vec_i | input | IW | Vector being taken |
| cmpl_i | input | 1 | Completion strobe |
| cmpl_vec_i | input | IW | Vector completing |
| pending_o | output | NUM_VEC | Pending bits |
| active_o | output | NUM_VEC | Active bits |
| forced_o | output | 1 | Sticky forced-fault flag |
| lockup_o | output | 1 | Lockup pulse |
| cmpl_valid_o | output | 1 | Completion response valid |
| cmpl_base_o | output | 1 | Return to base level |
| cmpl_err_o | output | 1 | Completion of an inactive vector |

## Verification
The assertions check the following properties on every cycle:
- an acknowledge leaves the vector active;
- a clear leaves it not pending;
- the forced flag never falls;
- a lockup never touches the forced flag;
- the error and return-to-base flags match the active set seen before the completion;
- each line rise, unless cleared in the same cycle, yields a pending bit.

Only the bench scenarios can show the following:
- which vector escalation redirects to;
- the equal-priority and range boundaries;
- re-pending on completion with a line still high;
- that a steady or falling line pends nothing;
- the same-cycle ordering of completion before acknowledge and clear after set.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int EXT_BASE = 16;  // first vector driven by an external line
  localparam int HF_VEC   = 3;   // hard fault vector, target of escalation
  localparam int PSV_VEC  = 14;  // first vector above the escalating range
  localparam int PRIO_W   = 8;   // per-vector priority width
  localparam int EXEC_W   = 10;  // signed execution priority width
endpackage

// File: rtl/exc_line_edge.sv
module exc_line_edge #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] level_q;

  for (genvar k = 0; k < N; k++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q[k] <= 1'b0;
      else        level_q[k] <= line_i[k];
    end
    assign rise_o[k] = line_i[k] & ~level_q[k];
  end

  assign level_o = level_q;
endmodule

// File: rtl/exc_escalate.sv
module exc_escalate
  import exc_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int IW      = 5
) (
  input  logic                      req_i,
  input  logic [IW-1:0]             req_vec_i,
  input  logic [NUM_VEC-1:0]        vec_en_i,
  input  logic [NUM_VEC*PRIO_W-1:0] vec_prio_i,
  input  logic signed [EXEC_W-1:0]  exec_prio_i,
  output logic                      pend_o,
  output logic [IW-1:0]             pend_vec_o,
  output logic                      forced_o,
  output logic                      lockup_o
);
  logic                     legal, fault, esc;
  logic [IW-1:0]            safe;
  logic signed [EXEC_W-1:0] vprio;

  always_comb begin
    legal = req_i && (int'(req_vec_i) != 0) && (int'(req_vec_i) < NUM_VEC);
    safe  = legal ? req_vec_i : '0;
    fault = (int'(safe) >= HF_VEC) && (int'(safe) < PSV_VEC);
    if (int'(safe) == HF_VEC) vprio = -1;
    else vprio = signed'({{(EXEC_W-PRIO_W){1'b0}}, vec_prio_i[int'(safe)*PRIO_W +: PRIO_W]});
    esc = fault && ((vprio >= exec_prio_i) ||
                    (!vec_en_i[safe] && (int'(safe) != HF_VEC)));
    lockup_o   = legal && esc && (exec_prio_i < 0);
    pend_o     = legal && !lockup_o;
    pend_vec_o = esc ? IW'(HF_VEC) : safe;
    forced_o   = legal && esc && !lockup_o;
  end
endmodule

// File: rtl/exc_vec_state.sv
module exc_vec_state #(
  parameter int NUM_VEC = 32,
  parameter int IW      = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmpl_ok_i,
  input  logic [IW-1:0]      cmpl_vec_i,
  input  logic               repend_i,
  input  logic               ack_ok_i,
  input  logic [IW-1:0]      ack_vec_i,
  input  logic [NUM_VEC-1:0] rise_i,
  input  logic               set_ok_i,
  input  logic [IW-1:0]      set_vec_i,
  input  logic               clr_ok_i,
  input  logic [IW-1:0]      clr_vec_i,
  output logic [NUM_VEC-1:0] pend_o,
  output logic [NUM_VEC-1:0] act_o
);
  logic [NUM_VEC-1:0] pend_q, act_q, pend_d, act_d;

  // fixed order: completion, acknowledge, rises and set, clear
  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    if (cmpl_ok_i) begin
      act_d[cmpl_vec_i] = 1'b0;
      if (repend_i) pend_d[cmpl_vec_i] = 1'b1;
    end
    if (ack_ok_i) begin
      act_d[ack_vec_i]  = 1'b1;
      pend_d[ack_vec_i] = 1'b0;
    end
    pend_d = pend_d | rise_i;
    if (set_ok_i) pend_d[set_vec_i] = 1'b1;
    if (clr_ok_i) pend_d[clr_vec_i] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;

  assert_ack_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok_i |=> act_q[$past(ack_vec_i)]);
  assert_clear_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok_i |=> !pend_q[$past(clr_vec_i)]);
endmodule

// File: rtl/exc_lifecycle.sv
module exc_lifecycle
  import exc_pkg::*;
#(
  parameter  int NUM_LINES = 16,
  localparam int NUM_VEC   = EXT_BASE + NUM_LINES,
  localparam int IW        = $clog2(NUM_VEC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_LINES-1:0]      line_i,
  input  logic [NUM_VEC-1:0]        vec_en_i,
  input  logic [NUM_VEC*PRIO_W-1:0] vec_prio_i,
  input  logic [EXEC_W-1:0]         exec_prio_i,
  input  logic                      set_i,
  input  logic [IW-1:0]             set_vec_i,
  input  logic                      clr_i,
  input  logic [IW-1:0]             clr_vec_i,
  input  logic                      ack_i,
  input  logic [IW-1:0]             ack_vec_i,
  input  logic                      cmpl_i,
  input  logic [IW-1:0]             cmpl_vec_i,
  output logic [NUM_VEC-1:0]        pending_o,
  output logic [NUM_VEC-1:0]        active_o,
  output logic                      forced_o,
  output logic                      lockup_o,
  output logic                      cmpl_valid_o,
  output logic                      cmpl_base_o,
  output logic                      cmpl_err_o
);
  logic [NUM_LINES-1:0] level_q, rise;
  logic [NUM_VEC-1:0]   rise_vec;
  logic                 esc_pend, esc_forced, esc_lock;
  logic [IW-1:0]        esc_vec;
  logic                 cmpl_ok, ack_ok, clr_ok, repend, base_now;
  logic                 forced_q, lockup_q, cv_q, base_q, err_q;

  exc_line_edge #(.N(NUM_LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .level_o(level_q), .rise_o(rise));

  assign rise_vec = {rise, {EXT_BASE{1'b0}}};

  exc_escalate #(.NUM_VEC(NUM_VEC), .IW(IW)) u_esc (
    .req_i(set_i), .req_vec_i(set_vec_i), .vec_en_i(vec_en_i),
    .vec_prio_i(vec_prio_i), .exec_prio_i(signed'(exec_prio_i)),
    .pend_o(esc_pend), .pend_vec_o(esc_vec), .forced_o(esc_forced),
    .lockup_o(esc_lock));

  always_comb begin
    cmpl_ok  = cmpl_i && (int'(cmpl_vec_i) != 0) && (int'(cmpl_vec_i) < NUM_VEC)
               && active_o[cmpl_vec_i];
    ack_ok   = ack_i && (int'(ack_vec_i) != 0) && (int'(ack_vec_i) < NUM_VEC);
    clr_ok   = clr_i && (int'(clr_vec_i) != 0) && (int'(clr_vec_i) < NUM_VEC);
    repend   = 1'b0;
    for (int k = 0; k < NUM_LINES; k++)
      if (int'(cmpl_vec_i) == EXT_BASE + k) repend = level_q[k];
    base_now = (active_o & (active_o - 1'b1)) == '0;
  end

  exc_vec_state #(.NUM_VEC(NUM_VEC), .IW(IW)) u_state (
    .clk(clk), .rst_n(rst_n),
    .cmpl_ok_i(cmpl_ok), .cmpl_vec_i(cmpl_vec_i), .repend_i(repend),
    .ack_ok_i(ack_ok), .ack_vec_i(ack_vec_i), .rise_i(rise_vec),
    .set_ok_i(esc_pend), .set_vec_i(esc_vec),
    .clr_ok_i(clr_ok), .clr_vec_i(clr_vec_i),
    .pend_o(pending_o), .act_o(active_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      forced_q <= 1'b0;
      lockup_q <= 1'b0;
      cv_q     <= 1'b0;
      base_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      forced_q <= forced_q | esc_forced;
      lockup_q <= esc_lock;
      cv_q     <= cmpl_i;
      base_q   <= cmpl_ok && base_now;
      err_q    <= cmpl_i && !cmpl_ok;
    end
  end

  assign forced_o     = forced_q;
  assign lockup_o     = lockup_q;
  assign cmpl_valid_o = cv_q;
  assign cmpl_base_o  = base_q;
  assign cmpl_err_o   = err_q;

  assert_forced_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    forced_o |=> forced_o);
  assert_lockup_keeps_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lockup_o |-> forced_o == $past(forced_o));
  assert_inactive_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_i && (int'(cmpl_vec_i) < NUM_VEC) |=>
      cmpl_valid_o && (cmpl_err_o == !$past(active_o[cmpl_vec_i])));
  assert_base_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_i && (int'(cmpl_vec_i) < NUM_VEC) && active_o[cmpl_vec_i] |=>
      cmpl_base_o == ($countones($past(active_o)) <= 1));

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_rise_chk
    assert_line_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      line_i[k] && !level_q[k] && !(clr_i && (int'(clr_vec_i) == EXT_BASE + k))
        |=> pending_o[EXT_BASE + k]);
  end
endmodule

// File: tb/test_exc_lifecycle.sv
module test_exc_lifecycle;
  localparam int NL = 16;
  localparam int NV = 32;

  typedef struct {
    logic [NV-1:0] pend, act;
    logic forced, lock, cv, base, err;
    string tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NL-1:0]   line;
  logic [NV-1:0]   en;
  logic [NV*8-1:0] prio;
  logic [9:0]      exec;
  logic set, clr, ack, cmpl;
  logic [4:0] set_v, clr_v, ack_v, cmpl_v;
  logic [NV-1:0] pend_o, act_o;
  logic forced_o, lockup_o, cv_o, base_o, err_o;

  exp_t q[$];
  logic [NV-1:0] e_pend, e_act;
  logic e_forced, e_lock, e_cv, e_base, e_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  exc_lifecycle #(.NUM_LINES(NL)) i_exc_lifecycle (
    .clk(clk), .rst_n(rst_n), .line_i(line), .vec_en_i(en), .vec_prio_i(prio),
    .exec_prio_i(exec), .set_i(set), .set_vec_i(set_v), .clr_i(clr),
    .clr_vec_i(clr_v), .ack_i(ack), .ack_vec_i(ack_v), .cmpl_i(cmpl),
    .cmpl_vec_i(cmpl_v), .pending_o(pend_o), .active_o(act_o),
    .forced_o(forced_o), .lockup_o(lockup_o), .cmpl_valid_o(cv_o),
    .cmpl_base_o(base_o), .cmpl_err_o(err_o));

  // driver: push the expectation for the coming edge, then advance one cycle
  task automatic tick(input string tag);
    exp_t it;
    it.pend = e_pend; it.act = e_act; it.forced = e_forced; it.lock = e_lock;
    it.cv = e_cv; it.base = e_base; it.err = e_err; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    set = 0; clr = 0; ack = 0; cmpl = 0;
    e_lock = 0; e_cv = 0; e_base = 0; e_err = 0;
  endtask

  task automatic do_set(input int v);  set = 1; set_v = 5'(v);  endtask
  task automatic do_clr(input int v);  clr = 1; clr_v = 5'(v);  endtask
  task automatic do_ack(input int v);  ack = 1; ack_v = 5'(v);  endtask
  task automatic do_cmpl(input int v); cmpl = 1; cmpl_v = 5'(v); endtask

  // monitor: compare one expectation shortly after each rising edge
  initial forever begin
    @(posedge clk); #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (pend_o !== it.pend || act_o !== it.act || forced_o !== it.forced ||
          lockup_o !== it.lock || cv_o !== it.cv || base_o !== it.base || err_o !== it.err) begin
        errors++;
        $display("FAIL %s: pend=%h act=%h f=%b l=%b v=%b b=%b e=%b expected pend=%h act=%h f=%b l=%b v=%b b=%b e=%b",
          it.tag, pend_o, act_o, forced_o, lockup_o, cv_o, base_o, err_o,
          it.pend, it.act, it.forced, it.lock, it.cv, it.base, it.err);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    line = '0; en = '1; prio = {NV{8'h40}}; exec = 10'd256;
    set = 0; clr = 0; ack = 0; cmpl = 0; set_v = 0; clr_v = 0; ack_v = 0; cmpl_v = 0;
    e_pend = '0; e_act = '0; e_forced = 0; e_lock = 0; e_cv = 0; e_base = 0; e_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick("R1 reset state");

    do_set(20); e_pend[20] = 1; tick("R2 set");
    do_clr(20); e_pend[20] = 0; tick("R2 clear");
    do_clr(20); tick("R2 clear of idle vector");
    do_set(0); tick("R2 index zero ignored");

    do_set(20); e_pend[20] = 1; tick("R2 set again");
    do_ack(20); e_act[20] = 1; e_pend[20] = 0; tick("R5 acknowledge");
    do_cmpl(20); e_act[20] = 0; e_cv = 1; e_base = 1; tick("R7 single active");
    do_cmpl(20); e_cv = 1; e_err = 1; tick("R6 inactive completion");

    do_set(17); e_pend[17] = 1; tick("R2 set 17");
    do_ack(17); e_pend[17] = 0; e_act[17] = 1; tick("R5 ack 17");
    do_set(18); e_pend[18] = 1; tick("R2 set 18");
    do_ack(18); e_pend[18] = 0; e_act[18] = 1; tick("R5 ack 18");
    do_cmpl(18); e_act[18] = 0; e_cv = 1; e_base = 0; tick("R7 nested not base");
    do_cmpl(17); e_act[17] = 0; e_cv = 1; e_base = 1; tick("R7 last to base");

    exec = 10'h3FF;  // -1
    do_set(6); e_lock = 1; tick("R4 lockup");
    tick("R4 lockup single pulse");
    do_set(3); e_lock = 1; tick("R4 hard fault at negative priority");
    exec = 10'd256;

    en[5] = 0;
    do_set(5); e_pend[3] = 1; e_forced = 1; tick("R3 disabled fault escalates");
    en[5] = 1;
    do_ack(3); e_pend[3] = 0; e_act[3] = 1; tick("R5 ack hard fault");
    do_cmpl(3); e_act[3] = 0; e_cv = 1; e_base = 1; tick("R7 hard fault done");
    exec = 10'h040;
    do_set(4); e_pend[3] = 1; tick("R3 equal priority escalates");
    exec = 10'h041;
    do_set(4); e_pend[4] = 1; tick("R3 higher priority not escalated");
    exec = 10'd256;
    do_clr(3); e_pend[3] = 0; tick("R2 clear 3");
    do_clr(4); e_pend[4] = 0; tick("R2 clear 4");
    en[14] = 0; exec = 10'd0;
    do_set(14); e_pend[14] = 1; tick("R3 vector 14 outside range");
    en[14] = 1; exec = 10'd256;
    do_clr(14); e_pend[14] = 0; tick("R2 clear 14");

    line[1] = 1; e_pend[17] = 1; tick("R9 rising edge");
    do_clr(17); e_pend[17] = 0; tick("R2 clear 17");
    tick("R9 steady high no pend");
    line[1] = 0; tick("R9 falling edge no pend");
    line[1] = 1; e_pend[17] = 1; tick("R9 second rise");

    do_ack(17); e_pend[17] = 0; e_act[17] = 1; tick("R5 ack line vector");
    do_cmpl(17); e_act[17] = 0; e_pend[17] = 1; e_cv = 1; e_base = 1; tick("R8 repend on completion");
    line[1] = 0; do_clr(17); e_pend[17] = 0; tick("R2 clear after line low");

    do_set(22); e_pend[22] = 1; tick("R2 set 22");
    do_ack(22); e_pend[22] = 0; e_act[22] = 1; tick("R5 ack 22");
    do_set(22); e_pend[22] = 1; tick("R2 set 22 while active");
    do_cmpl(22); do_ack(22); e_pend[22] = 0; e_act[22] = 1; e_cv = 1; e_base = 1;
    tick("R10 completion before acknowledge");
    do_cmpl(22); e_act[22] = 0; e_cv = 1; e_base = 1; tick("R7 finish 22");
    do_set(23); do_clr(23); tick("R10 clear after set");
    line[2] = 1; do_clr(18); tick("R10 clear after line rise");
    line[2] = 0; tick("R9 idle");

    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule